// File: doc/BRIEF.md
# Sinc3 Decimation Filter with Run-Time Ratio Select

This block takes a one-bit oversampled stream from a sigma-delta modulator and turns it into 16-bit unsigned words at a lower rate. The stream is clocked in one bit per clock, and its density of ones carries the analog value. Three cascaded integrators run at the bit rate. Three cascaded differentiators run once per decimation period. Together they form a third-order sinc filter whose raw gain is R cubed, where R is the decimation ratio.

The ratio is chosen by a two-bit select: 256, 128 or 64. The filter result is shifted right by a ratio-dependent amount, so every ratio uses the same code scale. Density d maps to d·65536, and full density is clamped to 65535. After reset, and after every ratio change, the first three words are withheld while the differentiator delay lines settle. A one-cycle strobe marks each word that is delivered.

Top module: `sinc3_decim`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `word_vld` is 0 and `word_out` is 0.
- R2: `ratio_sel` encodes the ratio as follows: 0 selects 256, 1 selects 128, and 2 or 3 select 64. In steady state, successive strobes are exactly R clocks apart.
- R3: For a periodic input pattern whose period divides R, every delivered word equals floor(ones·65536/period). Examples are 1/2 giving 32768, 13/16 giving 53248, 31/64 giving 31744 and 5/8 giving 40960.
- R4: An all-ones stream gives 65535 (saturated, never wrapping to 0). An all-zeros stream gives 0.
- R5: The same ones-density gives the same code at every ratio.
- R6: After reset is released, the first three decimation results are suppressed. The first strobe comes no earlier than 4·R clocks and no later than 4·R+8 clocks after release.
- R7: A new ratio is taken up at the first decimation boundary after it is presented. That boundary's word and the next two are suppressed. The gap from the last word at the old ratio to the first word at the new ratio is therefore R_old + 3·R_new clocks.
- R8: `word_vld` is high for exactly one clock per delivered word.
- R9: A change on `ratio_sel` that reverts before the next decimation boundary has no effect. The strobe spacing and the codes are unchanged, and no word is suppressed.
- R10: The integrators wrap modulo 2^25, and the differentiators undo the wrap. Long runs, including all-ones, keep delivering correct codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Modulator data bit, one per clock |
| ratio_sel | input | 2 | Decimation ratio select (0: 256, 1: 128, 2/3: 64) |
| word_out | output | 16 | Filtered unsigned output word |
| word_vld | output | 1 | One-cycle strobe marking a new word |

## Verification
The assertions assume that `bit_in` is always a defined 0 or 1. Under that assumption, a delivered word's differentiator result can never exceed R cubed, and decimation strobes are never adjacent. The full-scale bound is checked only on words the block chooses to deliver, because suppressed words that straddle a ratio change have mixed sample spacing. The stimulus uses periodic patterns whose period divides every ratio, so each expected code is exact whatever the phase. Ratio changes are made just after a strobe, so the boundary at which the new ratio takes effect is known in advance.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int unsigned SEL_W = 2;

  // Map the ratio select to log2 of the decimation ratio.
  function automatic int unsigned sel_to_lg(input logic [SEL_W-1:0] sel,
                                            input int unsigned lg_max);
    case (sel)
      2'd0:    return lg_max;
      2'd1:    return lg_max - 1;
      default: return lg_max - 2;
    endcase
  endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int W     = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] acc_last
);

  logic [W-1:0] acc [ORDER];

  genvar i;
  generate
    for (i = 0; i < ORDER; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) acc[i] <= '0;
          else     acc[i] <= acc[i] + {{(W-1){1'b0}}, bit_in};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) acc[i] <= '0;
          else     acc[i] <= acc[i] + acc[i-1];
        end
      end
    end
  endgenerate

  assign acc_last = acc[ORDER-1];

  // R10: the first integrator advances by at most one per bit, modulo 2^W
  assert_integ_step_R10: assert property (@(posedge clk) disable iff (rst)
    ((acc[0] - $past(acc[0])) <= W'(1)));

endmodule

// File: rtl/sinc3_ctl.sv
module sinc3_ctl
  import sinc3_pkg::*;
#(
  parameter int LG_MAX = 8,
  parameter int LGW    = 4,
  parameter int WARM   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             tc,
  output logic             keep,
  output logic [LGW-1:0]   lg_act
);

  localparam int CNT_W = LG_MAX;
  localparam int WRMW  = $clog2(WARM + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [LGW-1:0]   lg_req;
  logic [WRMW-1:0]  warm;
  logic             change;

  assign lg_req = LGW'(sel_to_lg(ratio_sel, LG_MAX));
  assign last   = CNT_W'((32'd1 << lg_act) - 32'd1);
  assign tc     = (cnt == last);
  assign change = (lg_req != lg_act);
  assign keep   = tc && (warm == WRMW'(WARM)) && !change;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      lg_act <= lg_req;
      warm   <= '0;
    end else if (tc) begin
      cnt <= '0;
      if (change) begin
        lg_act <= lg_req;
        warm   <= WRMW'(1);
      end else if (warm != WRMW'(WARM)) begin
        warm <= warm + WRMW'(1);
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R2: the decimation counter never passes the terminal count of the active ratio
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt <= last));

  // R9: the active ratio moves only at a decimation boundary
  assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tc |=> $stable(lg_act)));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int W   = 25,
  parameter int LGW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic           in_keep,
  input  logic [LGW-1:0] in_lg,
  input  logic [W-1:0]   in_data,
  output logic           out_vld,
  output logic           out_keep,
  output logic [LGW-1:0] out_lg,
  output logic [W-1:0]   out_data
);

  logic [W-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly      <= '0;
      out_vld  <= 1'b0;
      out_keep <= 1'b0;
      out_lg   <= '0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        dly      <= in_data;
        out_data <= in_data - dly;
        out_keep <= in_keep;
        out_lg   <= in_lg;
      end
    end
  end

  // R2: decimated samples arrive at most once every two clocks
  assert_comb_cadence_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld |=> !in_vld));

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
  parameter int W     = 25,
  parameter int LGW   = 4,
  parameter int ORDER = 3,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_keep,
  input  logic [LGW-1:0]   in_lg,
  input  logic [W-1:0]     in_data,
  output logic [OUT_W-1:0] word_out,
  output logic             word_vld
);

  localparam int SHW = $clog2(W) + 1;

  logic [SHW-1:0] shamt;
  logic [W-1:0]   shifted;
  logic           ovf;
  logic [W:0]     fs_lim;

  assign shamt   = SHW'(ORDER * int'(in_lg) - OUT_W);
  assign shifted = in_data >> shamt;
  assign ovf     = |shifted[W-1:OUT_W];
  assign fs_lim  = {{W{1'b0}}, 1'b1} << (ORDER * int'(in_lg));

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= in_vld && in_keep;
      if (in_vld && in_keep)
        word_out <= ovf ? {OUT_W{1'b1}} : shifted[OUT_W-1:0];
    end
  end

  // R4: a delivered filter result never exceeds the raw full-scale gain R^ORDER
  assert_full_scale_R4: assert property (@(posedge clk) disable iff (rst)
    ((in_vld && in_keep) |-> ({1'b0, in_data} <= fs_lim)));

  // R8: the output strobe lasts a single clock
  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (word_vld |=> !word_vld));

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int LG_MAX = 8,
  parameter int ORDER  = 3,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic [OUT_W-1:0] word_out,
  output logic             word_vld
);

  localparam int W   = ORDER * LG_MAX + 1;
  localparam int LGW = $clog2(LG_MAX + 1);

  logic [W-1:0]   int_last;
  logic           tc;
  logic           keep;
  logic [LGW-1:0] lg_act;

  logic [ORDER:0] c_vld;
  logic [ORDER:0] c_keep;
  logic [LGW-1:0] c_lg   [ORDER+1];
  logic [W-1:0]   c_data [ORDER+1];

  sinc3_integ #(.ORDER(ORDER), .W(W)) u_integ (
    .clk(clk), .rst(rst), .bit_in(bit_in), .acc_last(int_last)
  );

  sinc3_ctl #(.LG_MAX(LG_MAX), .LGW(LGW), .WARM(ORDER)) u_ctl (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel),
    .tc(tc), .keep(keep), .lg_act(lg_act)
  );

  assign c_vld[0]  = tc;
  assign c_keep[0] = keep;
  assign c_lg[0]   = lg_act;
  assign c_data[0] = int_last;

  genvar k;
  generate
    for (k = 0; k < ORDER; k++) begin : g_comb
      sinc3_comb #(.W(W), .LGW(LGW)) u_comb (
        .clk(clk), .rst(rst),
        .in_vld(c_vld[k]), .in_keep(c_keep[k]), .in_lg(c_lg[k]), .in_data(c_data[k]),
        .out_vld(c_vld[k+1]), .out_keep(c_keep[k+1]), .out_lg(c_lg[k+1]),
        .out_data(c_data[k+1])
      );
    end
  endgenerate

  sinc3_scale #(.W(W), .LGW(LGW), .ORDER(ORDER), .OUT_W(OUT_W)) u_scale (
    .clk(clk), .rst(rst),
    .in_vld(c_vld[ORDER]), .in_keep(c_keep[ORDER]), .in_lg(c_lg[ORDER]),
    .in_data(c_data[ORDER]),
    .word_out(word_out), .word_vld(word_vld)
  );

  // R1: the cycle after reset is released shows no word and a cleared output
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) |-> (!word_vld && (word_out == '0))));

endmodule

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic [15:0] word_out;
  logic        word_vld;

  always #5 clk = ~clk;

  sinc3_decim u0 (
    .clk(clk), .rst(rst), .bit_in(bit_in), .ratio_sel(ratio_sel),
    .word_out(word_out), .word_vld(word_vld)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int strobes = 0;
  int last_t = 0;
  int last_gap = 0;
  int skip = 0;
  int pat_ones = 1;
  int pat_len = 2;
  int phase = 0;
  bit prev_vld = 1'b0;
  bit done = 1'b0;

  int    exp_q [$];
  string tag_q [$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_range(input string tag, input longint act,
                           input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  function automatic int code_of(input int ones, input int len);
    longint v;
    v = (longint'(ones) * 65536) / len;
    return (v > 65535) ? 65535 : int'(v);
  endfunction

  // Driver side of the scoreboard: queue the expected codes.
  task automatic push_exp(input int ones, input int len, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(code_of(ones, len));
      tag_q.push_back(tag);
    end
  endtask

  task automatic run_case(input int ones, input int len, input int n, input string tag);
    pat_ones = ones;
    pat_len  = len;
    phase    = 0;
    skip     = 5;
    push_exp(ones, len, n, tag);
    while (exp_q.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_strobe();
    int s;
    s = strobes;
    while (strobes == s) begin
      @(negedge clk);
      #1;
    end
  endtask

  // Bit stream generator
  initial begin
    forever begin
      @(negedge clk);
      if (phase >= pat_len) phase = 0;
      bit_in = (phase < pat_ones);
      phase++;
    end
  end

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (word_vld) begin
          strobes++;
          last_gap = cyc - last_t;
          last_t   = cyc;
          chk("R8 strobe not adjacent to previous", prev_vld, 0);
          if (skip > 0) begin
            skip--;
          end else if (exp_q.size() != 0) begin
            chk(tag_q.pop_front(), word_out, exp_q.pop_front());
          end
        end
        prev_vld = word_vld;
      end else begin
        prev_vld = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t_rel;
    // R1: reset state
    pat_ones = 1; pat_len = 2; phase = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 word_vld in reset", word_vld, 0);
    chk("R1 word_out in reset", word_out, 0);
    push_exp(1, 2, 2, "R3 half density at R=256 after reset");
    rst = 1'b0;
    t_rel = cyc;
    @(negedge clk);
    #1;
    chk("R1 word_vld after release", word_vld, 0);
    chk("R1 word_out after release", word_out, 0);
    // R6: first three results suppressed
    wait_strobe();
    chk_range("R6 first strobe delay", last_t - t_rel, 4 * 256, 4 * 256 + 8);
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    chk("R2 spacing at R=256", last_gap, 256);

    run_case(13, 16, 2, "R3 13/16 density at R=256");
    run_case(31, 64, 2, "R3 31/64 density at R=256");
    run_case(5, 8, 2, "R3 5/8 density at R=256");
    run_case(1, 1, 2, "R4 all ones saturates at R=256");
    run_case(0, 1, 2, "R4 all zeros at R=256");

    // R7: switch to 128 right after a strobe
    run_case(1, 2, 1, "R3 half density before ratio change");
    wait_strobe();
    ratio_sel = 2'd1;
    push_exp(1, 2, 3, "R7 code after change to 128");
    wait_strobe();
    chk("R7 gap across change 256->128", last_gap, 256 + 3 * 128);
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    chk("R2 spacing at R=128", last_gap, 128);

    run_case(13, 16, 2, "R5 13/16 density at R=128");
    run_case(1, 1, 2, "R5 all ones at R=128");

    // R9: glitch on the select between boundaries
    pat_ones = 1; pat_len = 2; phase = 0; skip = 5;
    push_exp(1, 2, 1, "R3 half density at R=128");
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    ratio_sel = 2'd0;
    repeat (10) @(negedge clk);
    ratio_sel = 2'd1;
    push_exp(1, 2, 2, "R9 code unchanged after select glitch");
    wait_strobe();
    chk("R9 spacing unchanged after glitch", last_gap, 128);
    while (exp_q.size() != 0) begin @(negedge clk); #1; end

    // R7 and R2: code 3 selects 64
    wait_strobe();
    ratio_sel = 2'd3;
    push_exp(1, 2, 2, "R7 code after change to 64");
    wait_strobe();
    chk("R7 gap across change 128->64", last_gap, 128 + 3 * 64);
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    chk("R2 spacing at R=64 (select 3)", last_gap, 64);

    run_case(31, 64, 2, "R5 31/64 density at R=64");
    run_case(13, 16, 2, "R5 13/16 density at R=64");
    run_case(1, 1, 40, "R10 long all-ones run with wrapping integrators");
    run_case(1, 4, 3, "R3 1/4 density at R=64");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule